// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a 16-bit down-counter on a small register bus. A power-of-two prescaler paces it, and it runs in one of four modes. In free-running mode it wraps around and raises no event. Periodic mode raises an interrupt pulse and reloads. One-shot mode raises one interrupt and then switches itself off. In watchdog mode an expiry raises a reset request for the system.

Software programs a reload value and a control word. In watchdog mode, software keeps the system alive by rewriting the reload value before the count runs out. When the watchdog fires, the block sets a cause flag. This flag survives the ordinary block reset, so boot code can find out why the chip restarted. The flag is cleared only by a power-on reset or by an explicit write-one.

Top module: `pwdt_top`

## Requirements
- R1: After reset the block is in this state: the load, control and count registers read 0, `irq` and `wdt_rst_req` are low, and the counter does not move.
- R2: Register map. The reload value is at offset 0x00, in bits 15:0, and the upper bits are dropped. The control word is at 0x08 and holds three fields: bit 7 run enable, bits 5:4 mode, bits 3:0 prescale code. The cause word is at 0x04, bit 1. The live count is at 0x0C and is read-only. Unused bits and unmapped offsets read 0.
- R3: A prescale code c from 0 to 14 gives one count step every 2^c clocks. Code 15 gives one step every 65536 clocks. Steps are counted from the clock edge that enabled the counter or wrote the reload value.
- R4: A write to 0x00 loads the counter at once and restarts the prescaler. Expiry is a step taken while the count is 0, so an expiry falls (reload+1) steps after a load.
- R5: While the enable bit is 0, the count holds its value and no step is taken.
- R6: In mode 0 (free-running), the step after 0 gives 0xFFFF, and no interrupt is raised.
- R7: In mode 1 (periodic), each expiry raises `irq` for one clock and reloads the count from the reload register.
- R8: In mode 2 (one-shot), an expiry raises `irq` for one clock, clears the enable bit and leaves the count at 0.
- R9: In mode 3 (watchdog), an expiry raises `wdt_rst_req`, which stays high until `rst_n` is asserted. The same expiry sets the cause flag, and the count then stays at 0.
- R10: A reload write on the same clock edge as a watchdog expiry takes priority. No request is raised and a new timeout starts.
- R11: The cause flag survives `rst_n`. It is cleared by `por_n` or by writing 1 to bit 1 of 0x04. Writing 0 has no effect. If a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset (leaves the cause flag alone) |
| por_n | input | 1 | Asynchronous active-low power-on reset (clears everything) |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read |
| irq | output | 1 | One-clock timer interrupt pulse |
| wdt_rst_req | output | 1 | Held watchdog reset request |

## Verification
Two pairs of functions can fall on the same clock edge. The first pair is a keep-alive reload and the watchdog expiry it should cancel. The bench places the reload write exactly on the edge where the count would expire from 0. It then expects no request at that edge and a request exactly (reload+1) steps later. The second pair is the setting of the cause flag and a software write-one that clears it. The bench times the clear to land on the expiry edge and expects the flag to read 1 afterwards.

// File: rtl/pwdt_pkg.sv
package pwdt_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2,
        MODE_WATCHDOG = 2'd3
    } tmr_mode_e;

    // register offsets
    localparam int unsigned OFF_LOAD  = 32'h00;
    localparam int unsigned OFF_CAUSE = 32'h04;
    localparam int unsigned OFF_CTRL  = 32'h08;
    localparam int unsigned OFF_COUNT = 32'h0C;

    // control and cause field positions
    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_MODE_LSB = 4;
    localparam int CAUSE_WDT_BIT = 1;

endpackage

// File: rtl/pwdt_prescaler.sv
module pwdt_prescaler #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PRE_W = 1 << CODE_W;
    localparam int EXP_W = CODE_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [EXP_W-1:0] div_exp;
    logic [PRE_W-1:0] mask;

    // top code selects the full prescaler width, others select 2^code
    always_comb begin
        div_exp = (&code) ? EXP_W'(PRE_W) : {1'b0, code};
    end

    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (div_exp > EXP_W'(i));
    end

    always_comb begin
        st_d = st_q;
        if (!run || restart) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
        tick = run && (&(st_q.pre | ~mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwdt_counter.sv
module pwdt_counter
    import pwdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             kick,
    input  logic [CNT_W-1:0] kick_val,
    input  logic [CNT_W-1:0] reload_val,
    input  tmr_mode_e        mode,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             rst_req,
    output logic             wdt_fire,
    output logic             oneshot_fire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             req;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.irq     = 1'b0;
        wdt_fire     = 1'b0;
        oneshot_fire = 1'b0;
        if (kick) begin
            st_d.cnt = kick_val;
        end else if (tick && !st_q.req) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                case (mode)
                    MODE_FREE: begin
                        st_d.cnt = '1;
                    end
                    MODE_PERIODIC: begin
                        st_d.irq = 1'b1;
                        st_d.cnt = reload_val;
                    end
                    MODE_ONESHOT: begin
                        st_d.irq     = 1'b1;
                        oneshot_fire = 1'b1;
                    end
                    MODE_WATCHDOG: begin
                        st_d.req = 1'b1;
                        wdt_fire = 1'b1;
                    end
                    default: begin
                        st_d.cnt = st_q.cnt;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign irq     = st_q.irq;
    assign rst_req = st_q.req;
endmodule

// File: rtl/pwdt_regs.sv
module pwdt_regs
    import pwdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              cause,
    input  logic              oneshot_fire,
    output logic [CNT_W-1:0]  reload_val,
    output logic              en,
    output tmr_mode_e         mode,
    output logic [CODE_W-1:0] code,
    output logic              kick,
    output logic              cause_clr
);
    typedef struct packed {
        logic [CNT_W-1:0]  load;
        logic              en;
        tmr_mode_e         mode;
        logic [CODE_W-1:0] code;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       wr, rd, ctrl_wr;
    logic       unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    always_comb begin
        wr        = bus_en && bus_we;
        rd        = bus_en && !bus_we;
        kick      = wr && (bus_addr == ADDR_W'(OFF_LOAD));
        ctrl_wr   = wr && (bus_addr == ADDR_W'(OFF_CTRL));
        cause_clr = wr && (bus_addr == ADDR_W'(OFF_CAUSE)) && bus_wdata[CAUSE_WDT_BIT];

        st_d = st_q;
        if (kick) begin
            st_d.load = bus_wdata[CNT_W-1:0];
        end
        if (ctrl_wr) begin
            st_d.en   = bus_wdata[CTRL_EN_BIT];
            st_d.mode = tmr_mode_e'(bus_wdata[CTRL_MODE_LSB +: 2]);
            st_d.code = bus_wdata[CODE_W-1:0];
        end else if (oneshot_fire) begin
            st_d.en = 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (bus_addr == ADDR_W'(OFF_LOAD)) begin
                bus_rdata[CNT_W-1:0] = st_q.load;
            end else if (bus_addr == ADDR_W'(OFF_CAUSE)) begin
                bus_rdata[CAUSE_WDT_BIT] = cause;
            end else if (bus_addr == ADDR_W'(OFF_CTRL)) begin
                bus_rdata[CTRL_EN_BIT]          = st_q.en;
                bus_rdata[CTRL_MODE_LSB +: 2]   = st_q.mode;
                bus_rdata[CODE_W-1:0]           = st_q.code;
            end else if (bus_addr == ADDR_W'(OFF_COUNT)) begin
                bus_rdata[CNT_W-1:0] = count;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{load: '0, en: 1'b0, mode: MODE_FREE, code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_val = st_q.load;
    assign en         = st_q.en;
    assign mode       = st_q.mode;
    assign code       = st_q.code;
endmodule

// File: rtl/pwdt_cause.sv
module pwdt_cause (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic wdt;
    } cause_state_t;

    cause_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.wdt = 1'b1;
        end else if (clr) begin
            st_d.wdt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.wdt;
endmodule

// File: rtl/pwdt_top.sv
module pwdt_top
    import pwdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdt_rst_req
);
    logic              blk_rst_n;
    logic              kick, cause_clr, tick;
    logic              en_q, cause_q, wdt_fire, oneshot_fire;
    logic [CNT_W-1:0]  load_q, cnt_q;
    logic [CODE_W-1:0] code_q;
    tmr_mode_e         mode_q;

    assign blk_rst_n = rst_n & por_n;

    pwdt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CODE_W(CODE_W)
    ) u_regs (
        .clk(clk), .rst_n(blk_rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(cnt_q), .cause(cause_q), .oneshot_fire(oneshot_fire),
        .reload_val(load_q), .en(en_q), .mode(mode_q), .code(code_q),
        .kick(kick), .cause_clr(cause_clr)
    );

    pwdt_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk(clk), .rst_n(blk_rst_n), .run(en_q), .restart(kick),
        .code(code_q), .tick(tick)
    );

    pwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(blk_rst_n), .tick(tick), .kick(kick),
        .kick_val(bus_wdata[CNT_W-1:0]), .reload_val(load_q), .mode(mode_q),
        .count(cnt_q), .irq(irq), .rst_req(wdt_rst_req),
        .wdt_fire(wdt_fire), .oneshot_fire(oneshot_fire)
    );

    pwdt_cause u_cause (
        .clk(clk), .por_n(por_n), .set(wdt_fire), .clr(cause_clr),
        .flag(cause_q)
    );
endmodule

// File: rtl/pwdt_checker.sv
module pwdt_checker
    import pwdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  wr_cnt,
    input logic              wr_clr_bit,
    input logic              irq,
    input logic              rst_req,
    input logic              cause,
    input logic              en,
    input logic [1:0]        mode,
    input logic [CNT_W-1:0]  cnt
);
    logic load_wr, ctrl_wr, clr_wr;
    assign load_wr = bus_en && bus_we && (bus_addr == ADDR_W'(OFF_LOAD));
    assign ctrl_wr = bus_en && bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
    assign clr_wr  = bus_en && bus_we && (bus_addr == ADDR_W'(OFF_CAUSE)) && wr_clr_bit;

    p_req_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |=> rst_req);

    p_cause_on_req_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(rst_req) |-> cause);

    p_cause_kept_r11: assert property (@(posedge clk) disable iff (!por_n)
        (cause && !clr_wr) |=> cause);

    p_irq_mode_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        irq |-> ($past(mode) == MODE_PERIODIC || $past(mode) == MODE_ONESHOT));

    p_hold_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!en && !load_wr) |=> $stable(cnt));

    p_oneshot_off_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (irq && mode == MODE_ONESHOT && !$past(ctrl_wr)) |-> !en);

    p_kick_load_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        load_wr |=> (cnt == $past(wr_cnt)));
endmodule

bind pwdt_top pwdt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pwdt_checker (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .wr_cnt(bus_wdata[CNT_W-1:0]), .wr_clr_bit(bus_wdata[1]),
    .irq(irq), .rst_req(wdt_rst_req), .cause(cause_q),
    .en(en_q), .mode(mode_q), .cnt(cnt_q)
);

// File: tb/test_pwdt_top.sv
module test_pwdt_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wdt_rst_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwdt_top i_pwdt_top (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wdt_rst_req(wdt_rst_req)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    int    exp_at[$];
    bit    exp_rst[$];
    string exp_req[$];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(int at, bit is_rst, string req);
        exp_at.push_back(at);
        exp_rst.push_back(is_rst);
        exp_req.push_back(req);
    endtask

    // scoreboard monitor: every event popped and compared against the queue
    task automatic take(bit is_rst);
        if (exp_at.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s: actual event kind %0d at cycle %0d expected none",
                     is_rst ? "R9" : "R7", is_rst, cyc);
        end else begin
            int    at  = exp_at.pop_front();
            bit    rk  = exp_rst.pop_front();
            string req = exp_req.pop_front();
            check(req, cyc, at);
            check(req, {31'b0, is_rst}, {31'b0, rk});
        end
    endtask

    bit prev_req = 1'b0;
    always @(negedge clk) begin
        if (!done && rst_n && por_n) begin
            if (irq === 1'b1) take(1'b0);
            if (wdt_rst_req === 1'b1 && !prev_req) take(1'b1);
        end
        prev_req = (wdt_rst_req === 1'b1);
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            check("R4 pending events", exp_at.size(), 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (!done && cyc > WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
            finish_run();
        end
    end

    task automatic bus_write(logic [7:0] addr, logic [31:0] data, output int at);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        at = cyc;
    endtask

    task automatic bus_read(logic [7:0] addr, output logic [31:0] data);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = addr;
        #1;
        data = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int          t;
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 req", wdt_rst_req, 0);
        bus_read(8'h08, rd); check("R1 ctrl", rd, 0);
        bus_read(8'h00, rd); check("R1 load", rd, 0);
        bus_read(8'h0C, rd); check("R1 count", rd, 0);
        bus_read(8'h04, rd); check("R1 cause", rd, 0);

        // R7 periodic, no division
        bus_write(8'h00, 32'd4, t);
        bus_write(8'h08, 32'h90, t);
        expect_ev(t + 5, 1'b0, "R7");
        expect_ev(t + 10, 1'b0, "R7");
        wait_cyc(11);
        bus_write(8'h08, 32'h10, t);
        bus_read(8'h0C, rd); check("R5 hold", rd, 2);
        wait_cyc(5);
        bus_read(8'h0C, rd); check("R5 still", rd, 2);

        // R3 divide by 4
        bus_write(8'h00, 32'd2, t);
        bus_write(8'h08, 32'h92, t);
        expect_ev(t + 12, 1'b0, "R3");
        wait_cyc(13);
        bus_write(8'h08, 32'h12, t);
        bus_read(8'h0C, rd); check("R3 count", rd, 2);

        // R8 one-shot
        bus_write(8'h00, 32'd3, t);
        bus_write(8'h08, 32'hA0, t);
        expect_ev(t + 4, 1'b0, "R8");
        wait_cyc(6);
        bus_read(8'h08, rd); check("R8 enable cleared", rd, 32'h20);
        bus_read(8'h0C, rd); check("R8 count", rd, 0);
        wait_cyc(10);

        // R6 free-running wrap
        bus_write(8'h00, 32'd1, t);
        bus_write(8'h08, 32'h80, t);
        wait_cyc(3);
        bus_read(8'h0C, rd); check("R6 wrap", rd, 32'hFFFE);
        bus_write(8'h08, 32'h00, t);

        // R9/R10 watchdog keep-alive and kick on the expiry edge
        bus_write(8'h00, 32'd5, t);
        bus_write(8'h08, 32'hB0, t);
        for (int k = 0; k < 4; k++) begin
            wait_cyc(3);
            bus_write(8'h00, 32'd5, t);
        end
        check("R10 kept alive", wdt_rst_req, 0);
        wait_cyc(5);
        bus_write(8'h00, 32'd5, t);
        check("R10 kick wins", wdt_rst_req, 0);
        expect_ev(t + 6, 1'b1, "R9");
        wait_cyc(5);
        check("R10 not yet", wdt_rst_req, 0);
        wait_cyc(1);
        check("R9 req", wdt_rst_req, 1);
        bus_read(8'h04, rd); check("R9 cause", rd, 32'h2);
        wait_cyc(3);
        bus_read(8'h0C, rd); check("R9 count held", rd, 0);
        check("R9 req held", wdt_rst_req, 1);

        // R11 cause survives block reset, write-one clear
        rst_n = 1'b0; wait_cyc(2); rst_n = 1'b1; wait_cyc(1);
        check("R1 req after rst", wdt_rst_req, 0);
        bus_read(8'h08, rd); check("R1 ctrl after rst", rd, 0);
        bus_read(8'h04, rd); check("R11 survives", rd, 32'h2);
        bus_write(8'h04, 32'h0, t);
        bus_read(8'h04, rd); check("R11 write zero", rd, 32'h2);
        bus_write(8'h04, 32'h2, t);
        bus_read(8'h04, rd); check("R11 write one", rd, 0);

        // R11 set beats clear on the same edge
        bus_write(8'h00, 32'd2, t);
        bus_write(8'h08, 32'hB0, t);
        expect_ev(t + 3, 1'b1, "R9");
        wait_cyc(2);
        bus_write(8'h04, 32'h2, t);
        bus_read(8'h04, rd); check("R11 set wins", rd, 32'h2);
        rst_n = 1'b0; wait_cyc(2); rst_n = 1'b1; wait_cyc(1);
        por_n = 1'b0; wait_cyc(2); por_n = 1'b1; wait_cyc(1);
        bus_read(8'h04, rd); check("R11 por clear", rd, 0);
        check("R1 req after por", wdt_rst_req, 0);

        // R2 register map and readback
        bus_write(8'h08, 32'hFFFF_FF4F, t);
        bus_read(8'h08, rd); check("R2 ctrl unused bits", rd, 32'h0F);
        bus_write(8'h00, 32'hABCD_1234, t);
        bus_read(8'h00, rd); check("R2 load width", rd, 32'h1234);
        bus_read(8'h0C, rd); check("R4 immediate load", rd, 32'h1234);
        bus_read(8'h10, rd); check("R2 unmapped", rd, 0);

        // R3 largest prescale code
        bus_write(8'h00, 32'd0, t);
        bus_write(8'h08, 32'h9F, t);
        expect_ev(t + 65536, 1'b0, "R3");
        bus_read(8'h08, rd); check("R2 ctrl fields", rd, 32'h9F);
        wait_cyc(65537);
        bus_write(8'h08, 32'h1F, t);
        wait_cyc(2);

        finish_run();
    end
endmodule